// File: doc/BRIEF.md
# Two-Level Interrupt Controller with Fast Path and Fixed-Priority Arbitration

This block collects interrupt requests from a set of main sources and a smaller set of sub-sources. Every request is recorded in a pending register whether or not it is masked. Each sub-source belongs to one parent main source. A sub-source pending bit that its sub-mask lets through keeps setting the pending bit of that parent. Unmasked main pending bits are then steered, bit by bit, by a mode register. Fast-mode bits drive the fast interrupt output directly. Normal-mode bits compete in a fixed-priority arbiter, and the winner is recorded as a single bit in an in-service register that drives the normal interrupt output.

Software reaches the block through a small synchronous register bus. Read data appears one cycle after the read strobe. The three pending registers clear bits that are written as 1. The mask and mode registers are plain read/write. After servicing a source, software clears its pending bit first and then its in-service bit.

Top module: `irq_ctrl2`

## Requirements
- R1: After reset, all pending bits and in-service bits read 0, every mask and sub-mask bit reads 1, every mode bit reads 0, and both interrupt outputs are low.
- R2: A one-cycle pulse on `src_req[k]` sets main pending bit k at the next clock edge, whatever the mask holds.
- R3: A pulse on `sub_req[i]` sets sub-pending bit i whatever the sub-mask holds. While sub-pending bit i is set and sub-mask bit i is 0, main pending bit `SUB_BASE + i / SUB_GROUP` is set on the following edge. With the defaults, sub-sources 3..5 map to bit 29 and sub-sources 9..10 map to bit 31.
- R4: A write to a pending register (main at address 0, in-service at address 3, sub-pending at address 4) clears exactly the bits written as 1 and leaves the other bits unchanged.
- R5: When a request and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R6: A pending bit that is unmasked and has mode bit 1 (fast) raises `fast_irq` at the edge where the bit or its enabling register changes, and it never enters the in-service register.
- R7: When the in-service register is empty, the lowest-index pending bit that is unmasked and has mode bit 0 is set as the only in-service bit on the next edge, and `norm_irq` is high exactly while any in-service bit is set.
- R8: While any in-service bit is set, no new winner is taken, even when a higher-priority request arrives.
- R9: A source whose mask bit is 1 raises neither interrupt output, but its pending bit still reads back as set.
- R10: If an in-service bit is cleared while its source pending bit is still set, that source is selected again on the following edge.
- R11: Register map: 0 main pending, 1 mode, 2 mask, 3 in-service, 4 sub-pending (low `N_SUB` bits), 5 sub-mask (low `N_SUB` bits). `bus_rdata` shows the addressed register one cycle after `bus_rd`, with the value it had when `bus_rd` was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | N_MAIN | Main-source request pulses |
| sub_req | input | N_SUB | Sub-source request pulses |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | N_MAIN | Write data |
| bus_rdata | output | N_MAIN | Read data, one cycle after the read strobe |
| fast_irq | output | 1 | Fast interrupt request |
| norm_irq | output | 1 | Arbitrated normal interrupt request |

## Verification
On every cycle, the assertions check the pending-register rules: requests always set their bits, write-1 clears remove only the written bits, and untouched bits hold. They also check that the in-service register holds at most one bit, that it stays frozen while occupied, that each new grant is an eligible candidate with no lower-index candidate, and that fast-mode sources never enter arbitration. Only the bench scenarios show the address decode and the read latency, the exact parent mapping of sub-sources, the masking effect seen at the outputs, the re-selection of a source whose pending bit was left set, and the clear ordering across two registers.

// File: rtl/irq_ctrl2_pkg.sv
package irq_ctrl2_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_PEND = 3'd0,
      A_MODE = 3'd1,
      A_MASK = 3'd2,
      A_INSV = 3'd3,
      A_SUBP = 3'd4,
      A_SUBM = 3'd5
   } reg_addr_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("irq_pend_reg: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= (q_o & ~clr_i) | set_i;
   end

   // R2 / R5: a request always leaves its bit set, even against a clear
   p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_o & $past(set_i)) == $past(set_i)));

   // R4: a cleared bit with no request drops
   p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_o & $past(clr_i & ~set_i)) == '0));

   // R4: untouched bits keep their value
   p_untouched_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_o & ~$past(set_i | clr_i)) == ($past(q_o) & ~$past(set_i | clr_i))));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int W            = 32,
   parameter bit LOWEST_FIRST = 1'b1
) (
   input  logic [W-1:0] req_i,
   output logic [W-1:0] grant_o
);
   if (W < 1) begin : g_bad_w
      $error("irq_prio_pick: W must be at least 1");
   end

   if (LOWEST_FIRST) begin : g_low
      always_comb begin
         logic found;
         found   = 1'b0;
         grant_o = '0;
         for (int k = 0; k < W; k++) begin
            if (req_i[k] && !found) begin
               grant_o[k] = 1'b1;
               found      = 1'b1;
            end
         end
      end
   end else begin : g_high
      always_comb begin
         logic found;
         found   = 1'b0;
         grant_o = '0;
         for (int k = W - 1; k >= 0; k--) begin
            if (req_i[k] && !found) begin
               grant_o[k] = 1'b1;
               found      = 1'b1;
            end
         end
      end
   end

   // R7: grant is one request at most, and exists whenever any request does
   always_comb begin
      a_grant_shape_r7: assert ($onehot0(grant_o) && ((grant_o & ~req_i) == '0)
                                && ((req_i != '0) == (grant_o != '0)));
   end
endmodule

// File: rtl/irq_ctrl2.sv
module irq_ctrl2
   import irq_ctrl2_pkg::*;
#(
   parameter int N_MAIN    = 32,
   parameter int N_SUB     = 11,
   parameter int SUB_BASE  = 28,
   parameter int SUB_GROUP = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_MAIN-1:0] src_req,
   input  logic [N_SUB-1:0]  sub_req,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [N_MAIN-1:0] bus_wdata,
   output logic [N_MAIN-1:0] bus_rdata,
   output logic              fast_irq,
   output logic              norm_irq
);
   localparam int SUB_LAST_PARENT = SUB_BASE + (N_SUB - 1) / SUB_GROUP;
   localparam int SUB_PAD         = N_MAIN - N_SUB;

   if (N_SUB < 1 || N_SUB >= N_MAIN) begin : g_bad_sub
      $error("irq_ctrl2: N_SUB must be in 1..N_MAIN-1");
   end
   if (SUB_GROUP < 1 || SUB_BASE < 0 || SUB_LAST_PARENT >= N_MAIN) begin : g_bad_map
      $error("irq_ctrl2: sub-source parent mapping falls outside the main sources");
   end

   logic [N_MAIN-1:0] pend_q, mode_q, mask_q, insv_q;
   logic [N_SUB-1:0]  subp_q, subm_q;
   logic [N_MAIN-1:0] pend_clr, insv_clr, merged, cand, pick;
   logic [N_SUB-1:0]  subp_clr;
   logic              insv_take;

   // write decode
   always_comb begin
      pend_clr = (bus_wr && bus_addr == A_PEND) ? bus_wdata : '0;
      insv_clr = (bus_wr && bus_addr == A_INSV) ? bus_wdata : '0;
      subp_clr = (bus_wr && bus_addr == A_SUBP) ? bus_wdata[N_SUB-1:0] : '0;
   end

   // sub-source stage
   irq_pend_reg #(.W(N_SUB)) u_subp (
      .clk(clk), .rst_n(rst_n), .set_i(sub_req), .clr_i(subp_clr), .q_o(subp_q));

   always_comb begin
      merged = '0;
      for (int i = 0; i < N_SUB; i++) begin
         if (subp_q[i] && !subm_q[i]) merged[SUB_BASE + i / SUB_GROUP] = 1'b1;
      end
   end

   // main stage
   irq_pend_reg #(.W(N_MAIN)) u_pend (
      .clk(clk), .rst_n(rst_n), .set_i(src_req | merged), .clr_i(pend_clr), .q_o(pend_q));

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         mask_q <= '1;
         subm_q <= '1;
      end else if (bus_wr) begin
         if (bus_addr == A_MODE) mode_q <= bus_wdata;
         if (bus_addr == A_MASK) mask_q <= bus_wdata;
         if (bus_addr == A_SUBM) subm_q <= bus_wdata[N_SUB-1:0];
      end
   end

   // mode split and arbitration
   assign cand     = pend_q & ~mask_q & ~mode_q;
   assign fast_irq = |(pend_q & ~mask_q & mode_q);

   irq_prio_pick #(.W(N_MAIN), .LOWEST_FIRST(1'b1)) u_pick (
      .req_i(cand), .grant_o(pick));

   assign insv_take = (insv_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         insv_q <= '0;
      else if (insv_take) insv_q <= pick;
      else                insv_q <= insv_q & ~insv_clr;
   end

   assign norm_irq = |insv_q;

   // read port, one cycle latency
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else if (bus_rd) begin
         case (bus_addr)
            A_PEND:  bus_rdata <= pend_q;
            A_MODE:  bus_rdata <= mode_q;
            A_MASK:  bus_rdata <= mask_q;
            A_INSV:  bus_rdata <= insv_q;
            A_SUBP:  bus_rdata <= {{SUB_PAD{1'b0}}, subp_q};
            A_SUBM:  bus_rdata <= {{SUB_PAD{1'b0}}, subm_q};
            default: bus_rdata <= '0;
         endcase
      end
   end

   // R7: at most one in-service bit at any time
   p_insv_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(insv_q));

   // R8: an occupied in-service register only loses written bits
   p_insv_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (insv_q != '0) |=> (insv_q == ($past(insv_q) & ~$past(insv_clr))));

   // R7: a fresh grant is an eligible source with no lower eligible index
   p_grant_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (insv_q == '0) |=> ((insv_q & ~$past(cand)) == '0)
                         && ((((insv_q - 1'b1) & $past(cand)) == '0) || insv_q == '0));

   // R6: fast-mode sources never get in service
   p_fast_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (insv_q == '0) |=> ((insv_q & $past(mode_q)) == '0));

   // R9: masked sources never get in service
   p_masked_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (insv_q == '0) |=> ((insv_q & $past(mask_q)) == '0));
endmodule

// File: tb/irq_ctrl2_test.sv
`timescale 1ns/1ps
module irq_ctrl2_test;
   import irq_ctrl2_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_req = '0;
   logic [10:0] sub_req = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        fast_irq, norm_irq;

   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   irq_ctrl2 uut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .sub_req(sub_req),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .fast_irq(fast_irq), .norm_irq(norm_irq));

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      @(negedge clk); d = bus_rdata; bus_rd = 1'b0;
   endtask

   task automatic pulse(input logic [31:0] m);
      @(negedge clk); src_req = m;
      @(negedge clk); src_req = '0;
   endtask

   task automatic sub_pulse(input logic [10:0] m);
      @(negedge clk); sub_req = m;
      @(negedge clk); sub_req = '0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 fast_irq", {31'b0, fast_irq}, 32'd0);
      check("R1 norm_irq", {31'b0, norm_irq}, 32'd0);
      rd(A_PEND, d); check("R1/R11 pending", d, 32'h0);
      rd(A_MODE, d); check("R1/R11 mode", d, 32'h0);
      rd(A_MASK, d); check("R1/R11 mask", d, 32'hFFFF_FFFF);
      rd(A_INSV, d); check("R1/R11 in-service", d, 32'h0);
      rd(A_SUBP, d); check("R1/R11 sub-pending", d, 32'h0);
      rd(A_SUBM, d); check("R1/R11 sub-mask", d, 32'h0000_07FF);
   endtask

   task automatic t_masked();
      logic [31:0] d;
      pulse(32'h20);
      @(negedge clk);
      check("R9 norm_irq masked", {31'b0, norm_irq}, 32'd0);
      rd(A_PEND, d); check("R2 pending set while masked", d, 32'h20);
      rd(A_INSV, d); check("R9 in-service empty", d, 32'h0);
      pulse(32'h88);
      wr(A_PEND, 32'h28);
      rd(A_PEND, d); check("R4 partial clear", d, 32'h80);
      wr(A_PEND, 32'hFFFF_FFFF);
      rd(A_PEND, d); check("R4 full clear", d, 32'h0);
   endtask

   task automatic t_priority();
      logic [31:0] d;
      wr(A_MASK, 32'h0);
      pulse(32'h210);
      @(negedge clk);
      check("R7 norm_irq high", {31'b0, norm_irq}, 32'd1);
      rd(A_INSV, d); check("R7 lowest index wins", d, 32'h10);
      pulse(32'h4);
      rd(A_INSV, d); check("R8 no preemption", d, 32'h10);
      wr(A_PEND, 32'h10); wr(A_INSV, 32'h10);
      rd(A_INSV, d); check("R7 next winner bit2", d, 32'h4);
      wr(A_PEND, 32'h4); wr(A_INSV, 32'h4);
      rd(A_INSV, d); check("R7 next winner bit9", d, 32'h200);
   endtask

   task automatic t_leftover();
      logic [31:0] d;
      wr(A_INSV, 32'h200);
      check("R8 in-service cleared", {31'b0, norm_irq}, 32'd0);
      rd(A_INSV, d); check("R10 reselected", d, 32'h200);
      wr(A_PEND, 32'h200); wr(A_INSV, 32'h200);
      @(negedge clk);
      check("R10 idle after ordered clear", {31'b0, norm_irq}, 32'd0);
      rd(A_INSV, d); check("R10 in-service empty", d, 32'h0);
   endtask

   task automatic t_fast();
      logic [31:0] d;
      wr(A_MODE, 32'h2);
      wr(A_MASK, 32'h2);
      pulse(32'h2);
      check("R9 fast masked", {31'b0, fast_irq}, 32'd0);
      rd(A_PEND, d); check("R9 fast pending latched", d, 32'h2);
      wr(A_MASK, 32'h0);
      check("R6 fast_irq high", {31'b0, fast_irq}, 32'd1);
      @(negedge clk);
      check("R6 norm_irq stays low", {31'b0, norm_irq}, 32'd0);
      rd(A_INSV, d); check("R6 no in-service bit", d, 32'h0);
      wr(A_PEND, 32'h2);
      check("R6 fast_irq drops", {31'b0, fast_irq}, 32'd0);
      wr(A_MODE, 32'h0);
   endtask

   task automatic t_race();
      logic [31:0] d;
      wr(A_MASK, 32'hFFFF_FFFF);
      @(negedge clk);
      src_req = 32'h40; bus_wr = 1'b1; bus_addr = A_PEND; bus_wdata = 32'h40;
      @(negedge clk);
      src_req = '0; bus_wr = 1'b0;
      rd(A_PEND, d); check("R5 request beats clear", d, 32'h40);
      wr(A_PEND, 32'h40);
      rd(A_PEND, d); check("R4 cleared after race", d, 32'h0);
   endtask

   task automatic t_sub();
      logic [31:0] d;
      sub_pulse(11'h010);
      rd(A_SUBP, d); check("R3 sub pending while sub-masked", d, 32'h10);
      rd(A_PEND, d); check("R3 no merge while sub-masked", d, 32'h0);
      wr(A_SUBM, 32'h7EF);
      rd(A_PEND, d); check("R3 merge into bit29", d, 32'h2000_0000);
      wr(A_SUBM, 32'h0);
      sub_pulse(11'h400);
      @(negedge clk);
      rd(A_PEND, d); check("R3 sub10 into bit31", d, 32'hA000_0000);
      wr(A_SUBP, 32'h7FF);
      wr(A_PEND, 32'hFFFF_FFFF);
      rd(A_SUBP, d); check("R4 sub-pending cleared", d, 32'h0);
      rd(A_PEND, d); check("R3 main clear holds", d, 32'h0);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(5.0 * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_masked();
      t_priority();
      t_leftover();
      t_fast();
      t_race();
      t_sub();
      repeat (2) @(negedge clk);
      report();
   end
endmodule